// File: doc/BRIEF.md
# Stackless Warp Split Table with Convergence Barriers

This block steers control flow for a single warp without a reconvergence stack. It holds a small table of thread groups ("splits"). Each split has a program counter, a lane mask and a blocked flag. Beside the table sits a file of named convergence barriers. Each barrier holds a participation mask and a pending mask. Each cycle a scheduler picks one unblocked split and presents its PC, mask and slot number to the issue stage. The issue stage then reports what that group executed as one event: a plain step, a barrier init, a branch, a barrier sync or a yield. The table updates on the clock edge that accepts the event.

Divergent branches split a group in two. Lanes that land on a PC already held by a runnable split join that split. A group that syncs on a barrier parks until every participating lane has arrived. At that point all parked groups of that barrier fuse into one group, which resumes after the sync. Yield lets a spinning group hand the issue slot to another split.

The event port uses a valid/ready handshake. `ev_ready` is high exactly when a split is presented (`iss_valid`). An event is consumed on a rising edge where both `ev_valid` and `ev_ready` are high, and it always applies to the split presented in that cycle. While `ev_ready` is low the issue stage must hold its event. The issue outputs are combinational from registered state, so the effect of an event is visible one cycle after acceptance.

Top module: `warp_split_unit`

## Requirements
- R1: After reset, slot 0 is the only valid split, with PC = START_PC (0) and all lanes set. `err_overflow` is low, and slot 0 is presented with `iss_valid` high.
- R2: A branch (ev_op = 2) whose taken lanes (`ev_taken` AND the mask) and not-taken lanes are both non-empty keeps the not-taken lanes in the issuing slot at PC+1. The taken lanes go to `ev_target` in the lowest free slot, unless R5 applies. No lane ever belongs to two valid splits.
- R3: A barrier sync (ev_op = 3) on barrier `ev_bar` with a non-empty participation mask, which does not complete the barrier, ORs the split's lanes into the pending mask and blocks the split. Blocked splits are never presented.
- R4: When a sync makes the pending mask equal the participation mask, every split blocked on that barrier and the syncing split are merged into the syncing slot. The merged split has the OR of their masks, PC = sync PC + 1, and is unblocked. The other slots are freed and the pending mask is cleared.
- R5: Branch lanes whose destination PC equals the PC of another valid, unblocked split are ORed into that split instead of taking a slot. A blocked split with an equal PC is not a merge target.
- R6: The scheduler presents the first unblocked valid slot, searching circularly from a pointer. An accepted yield (ev_op = 4) advances the split's PC by one and moves the pointer to the slot after it. Every other event leaves the pointer on the issuing slot, and steps (ev_op = 0, also codes 5 to 7) advance the PC by one.
- R7: A sync on a barrier whose participation mask is empty does not block; the split just moves to PC+1.
- R8: A split whose mask becomes zero is freed in the same edge, for example when all lanes of a branch join another split. No valid split ever has an empty mask.
- R9: Allocation takes the lowest-numbered free slot. If a split is needed and no slot is free, `err_overflow` sets and stays set; otherwise it stays low.
- R10: A barrier init (ev_op = 1) sets the barrier's participation mask to the issuing split's mask, clears its pending mask and advances the PC by one.
- R11: `ev_ready` equals `iss_valid`, and every event accepted with it is applied to the presented slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event offered by the issue stage |
| ev_ready | output | 1 | Event can be accepted this cycle |
| ev_op | input | 3 | 0 step, 1 barrier init, 2 branch, 3 barrier sync, 4 yield |
| ev_bar | input | 2 | Barrier index for init and sync |
| ev_taken | input | LANES (8) | Lanes whose branch condition is true |
| ev_target | input | PC_W (16) | Branch target PC |
| iss_valid | output | 1 | A runnable split is presented |
| iss_slot | output | 3 | Table slot of the presented split |
| iss_pc | output | PC_W (16) | PC of the presented split |
| iss_mask | output | LANES (8) | Lane mask of the presented split |
| err_overflow | output | 1 | Sticky: a split could not be allocated |

## Verification
Two functions fall in the same edge when a uniform branch sends all of a split's lanes onto another split's PC. The lanes are ORed into the other slot and the issuing slot is freed at once. The bench provokes this, and the scheduler must then wrap past the hole and present the enlarged split with the combined mask. Barrier completion and pending-mask update also coincide, both when the last of two groups arrives and when a lone group syncs on a barrier it initialised itself. In both cases the bench expects the unblocked merged split at sync PC + 1 in the very next cycle.

// File: rtl/wsu_pkg.sv
package wsu_pkg;

  typedef enum logic [2:0] {
    OP_STEP   = 3'd0,
    OP_BINIT  = 3'd1,
    OP_BRANCH = 3'd2,
    OP_BSYNC  = 3'd3,
    OP_YIELD  = 3'd4
  } wsu_op_e;

endpackage

// File: rtl/wsu_first_set.sv
module wsu_first_set #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);

  // lowest set bit wins: scan downward so the last write is the lowest index
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/wsu_rr_pick.sv
module wsu_rr_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  elig,
  input  logic [IW-1:0] ptr,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      automatic int unsigned j = (int'(ptr) + i) % N;
      if (!found && elig[j]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end

endmodule

// File: rtl/wsu_barrier_file.sv
module wsu_barrier_file #(
  parameter int LANES    = 8,
  parameter int BARRIERS = 4,
  parameter int BW       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_en,
  input  logic             sync_en,
  input  logic [BW-1:0]    bar_sel,
  input  logic [LANES-1:0] lanes_in,
  output logic [LANES-1:0] part_sel,
  output logic             done
);

  logic [LANES-1:0] part_q [BARRIERS];
  logic [LANES-1:0] pend_q [BARRIERS];
  logic [LANES-1:0] pend_sel;
  logic [LANES-1:0] pend_upd;

  assign part_sel = part_q[bar_sel];
  assign pend_sel = pend_q[bar_sel];
  assign pend_upd = pend_sel | lanes_in;
  assign done     = sync_en && (part_sel != '0) && (pend_upd == part_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BARRIERS; b++) begin
        part_q[b] <= '0;
        pend_q[b] <= '0;
      end
    end else if (init_en) begin
      part_q[bar_sel] <= lanes_in;
      pend_q[bar_sel] <= '0;
    end else if (sync_en && part_sel != '0) begin
      pend_q[bar_sel] <= done ? '0 : pend_upd;
    end
  end

  // a completed barrier starts its next round with nobody pending
  AST_DONE_RESETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (pend_q[$past(bar_sel)] == '0)); // R4

endmodule

// File: rtl/warp_split_unit.sv
module warp_split_unit
  import wsu_pkg::*;
#(
  parameter int          LANES    = 8,
  parameter int          ENTRIES  = 8,
  parameter int          BARRIERS = 4,
  parameter int          PC_W     = 16,
  parameter int unsigned START_PC = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_valid,
  output logic                ev_ready,
  input  logic [2:0]          ev_op,
  input  logic [((BARRIERS > 1) ? $clog2(BARRIERS) : 1)-1:0] ev_bar,
  input  logic [LANES-1:0]    ev_taken,
  input  logic [PC_W-1:0]     ev_target,
  output logic                iss_valid,
  output logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] iss_slot,
  output logic [PC_W-1:0]     iss_pc,
  output logic [LANES-1:0]    iss_mask,
  output logic                err_overflow
);

  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int BAR_W  = (BARRIERS > 1) ? $clog2(BARRIERS) : 1;

  // split table
  logic [ENTRIES-1:0] v_q, blk_q;
  logic [PC_W-1:0]    pc_q   [ENTRIES];
  logic [LANES-1:0]   msk_q  [ENTRIES];
  logic [BAR_W-1:0]   wbar_q [ENTRIES];
  logic [SLOT_W-1:0]  rr_q;
  logic               err_q;

  // scheduler
  logic [ENTRIES-1:0] elig;
  logic               pick_found;
  logic [SLOT_W-1:0]  cur;

  assign elig = v_q & ~blk_q;

  wsu_rr_pick #(.N(ENTRIES), .IW(SLOT_W)) u_pick (
    .elig  (elig),
    .ptr   (rr_q),
    .found (pick_found),
    .idx   (cur)
  );

  wsu_op_e          op;
  logic             fire;
  logic [PC_W-1:0]  cur_pc, pc_ft;
  logic [LANES-1:0] cur_msk, tk, nt, grp_or;
  logic [ENTRIES-1:0] other, eq_ft, eq_tg, free_v, wait_grp;
  logic [SLOT_W-1:0] nxt_slot;

  assign op        = wsu_op_e'(ev_op);
  assign iss_valid = pick_found;
  assign ev_ready  = pick_found;
  assign fire      = ev_valid && pick_found;
  assign cur_pc    = pc_q[cur];
  assign cur_msk   = msk_q[cur];
  assign pc_ft     = cur_pc + PC_W'(1);
  assign nxt_slot  = (cur == SLOT_W'(ENTRIES - 1)) ? '0 : cur + SLOT_W'(1);

  // lane split for a branch; a target equal to the fall-through is uniform
  always_comb begin
    if (ev_target == pc_ft) begin
      tk = cur_msk;
      nt = '0;
    end else begin
      tk = cur_msk & ev_taken;
      nt = cur_msk & ~ev_taken;
    end
  end

  always_comb begin
    grp_or = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      other[i]    = elig[i] && (SLOT_W'(i) != cur);
      eq_ft[i]    = other[i] && (pc_q[i] == pc_ft);
      eq_tg[i]    = other[i] && (pc_q[i] == ev_target);
      free_v[i]   = !v_q[i];
      wait_grp[i] = v_q[i] && blk_q[i] && (wbar_q[i] == ev_bar);
      if (wait_grp[i]) grp_or = grp_or | msk_q[i];
    end
  end

  logic              m0_hit, m1_hit, f_hit;
  logic [SLOT_W-1:0] m0_idx, m1_idx, f_idx;

  wsu_first_set #(.N(ENTRIES), .IW(SLOT_W)) u_match_ft (
    .req (eq_ft), .hit (m0_hit), .idx (m0_idx));
  wsu_first_set #(.N(ENTRIES), .IW(SLOT_W)) u_match_tg (
    .req (eq_tg), .hit (m1_hit), .idx (m1_idx));
  wsu_first_set #(.N(ENTRIES), .IW(SLOT_W)) u_free (
    .req (free_v), .hit (f_hit), .idx (f_idx));

  // where each branch destination lands
  logic d0_on, d1_on, d0_self, d1_self, d1_alloc;
  assign d0_on    = nt != '0;
  assign d1_on    = tk != '0;
  assign d0_self  = d0_on && !m0_hit;
  assign d1_self  = d1_on && !m1_hit && !d0_self;
  assign d1_alloc = d1_on && !m1_hit && d0_self;

  // barriers
  logic [LANES-1:0] part_sel;
  logic             bar_done;
  logic             bar_init_en, bar_sync_en;

  assign bar_init_en = fire && (op == OP_BINIT);
  assign bar_sync_en = fire && (op == OP_BSYNC);

  wsu_barrier_file #(.LANES(LANES), .BARRIERS(BARRIERS), .BW(BAR_W)) u_bars (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_en  (bar_init_en),
    .sync_en  (bar_sync_en),
    .bar_sel  (ev_bar),
    .lanes_in (cur_msk),
    .part_sel (part_sel),
    .done     (bar_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q   <= ENTRIES'(1);
      blk_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        pc_q[i]   <= PC_W'(START_PC);
        msk_q[i]  <= (i == 0) ? '1 : '0;
        wbar_q[i] <= '0;
      end
      rr_q  <= '0;
      err_q <= 1'b0;
    end else if (fire) begin
      case (op)
        OP_BRANCH: begin
          if (d0_on && m0_hit) msk_q[m0_idx] <= msk_q[m0_idx] | nt;
          if (d1_on && m1_hit) msk_q[m1_idx] <= msk_q[m1_idx] | tk;
          if (d0_self) begin
            pc_q[cur]  <= pc_ft;
            msk_q[cur] <= nt;
          end else if (d1_self) begin
            pc_q[cur]  <= ev_target;
            msk_q[cur] <= tk;
          end else begin
            v_q[cur]   <= 1'b0;
            msk_q[cur] <= '0;
          end
          if (d1_alloc) begin
            if (f_hit) begin
              v_q[f_idx]   <= 1'b1;
              blk_q[f_idx] <= 1'b0;
              pc_q[f_idx]  <= ev_target;
              msk_q[f_idx] <= tk;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        OP_BSYNC: begin
          if (part_sel == '0) begin
            pc_q[cur] <= pc_ft;
          end else if (bar_done) begin
            for (int i = 0; i < ENTRIES; i++) begin
              if (wait_grp[i]) begin
                v_q[i]   <= 1'b0;
                blk_q[i] <= 1'b0;
                msk_q[i] <= '0;
              end
            end
            pc_q[cur]  <= pc_ft;
            msk_q[cur] <= cur_msk | grp_or;
          end else begin
            blk_q[cur]  <= 1'b1;
            wbar_q[cur] <= ev_bar;
          end
        end
        default: pc_q[cur] <= pc_ft;
      endcase
      rr_q <= (op == OP_YIELD) ? nxt_slot : cur;
    end
  end

  assign iss_slot     = cur;
  assign iss_pc       = cur_pc;
  assign iss_mask     = cur_msk;
  assign err_overflow = err_q;

  // ---------------- assertions ----------------
  logic lanes_overlap, empty_valid;
  always_comb begin
    automatic logic [LANES-1:0] seen = '0;
    lanes_overlap = 1'b0;
    empty_valid   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (v_q[i]) begin
        if ((seen & msk_q[i]) != '0) lanes_overlap = 1'b1;
        if (msk_q[i] == '0) empty_valid = 1'b1;
        seen = seen | msk_q[i];
      end
    end
  end

  AST_ISSUE_RUNNABLE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (v_q[iss_slot] && !blk_q[iss_slot])); // R3
  AST_LANES_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    !lanes_overlap); // R2
  AST_NO_EMPTY_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_valid); // R8
  AST_YIELD_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_YIELD && $countones(elig) > 1) |=> (iss_slot != $past(iss_slot))); // R6
  AST_SYNC_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_sync_en && part_sel != '0 && !bar_done)
      |=> (!iss_valid || iss_slot != $past(iss_slot))); // R3
  AST_EMPTY_BAR_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_sync_en && part_sel == '0)
      |=> (iss_valid && iss_pc == $past(iss_pc) + PC_W'(1))); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_overflow) |-> err_overflow); // R9

endmodule

// File: tb/warp_split_unit_tb_top.sv
module warp_split_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0;
  logic       ev_ready;
  logic [2:0] ev_op = '0;
  logic [1:0] ev_bar = '0;
  logic [7:0] ev_taken = '0;
  logic [15:0] ev_target = '0;
  logic       iss_valid;
  logic [2:0] iss_slot;
  logic [15:0] iss_pc;
  logic [7:0] iss_mask;
  logic       err_overflow;

  always #10 clk = ~clk; // 50 MHz

  warp_split_unit dut_i (
    .clk (clk), .rst_n (rst_n),
    .ev_valid (ev_valid), .ev_ready (ev_ready), .ev_op (ev_op),
    .ev_bar (ev_bar), .ev_taken (ev_taken), .ev_target (ev_target),
    .iss_valid (iss_valid), .iss_slot (iss_slot), .iss_pc (iss_pc),
    .iss_mask (iss_mask), .err_overflow (err_overflow)
  );

  typedef struct {
    logic [15:0] pc;
    logic [7:0]  mask;
    logic [2:0]  slot;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: offers one event and queues the split expected one cycle later
  task automatic ev(input logic [2:0] op, input logic [1:0] bar, input logic [7:0] taken,
                    input logic [15:0] tgt, input logic [15:0] e_pc, input logic [7:0] e_mask,
                    input logic [2:0] e_slot, input string tag);
    exp_t e;
    @(negedge clk);
    chk(ev_ready === 1'b1, "R11 ready", {31'd0, ev_ready}, 32'd1);
    ev_valid  = 1'b1;
    ev_op     = op;
    ev_bar    = bar;
    ev_taken  = taken;
    ev_target = tgt;
    e.pc = e_pc; e.mask = e_mask; e.slot = e_slot; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
  endtask

  // monitor: compares presented split after each accepted event
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(iss_valid === 1'b1 && iss_pc === e.pc && iss_mask === e.mask && iss_slot === e.slot,
            e.tag, {4'd0, iss_valid, iss_slot, iss_mask, iss_pc},
            {4'd0, 1'b1, e.slot, e.mask, e.pc});
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(iss_valid === 1'b1 && iss_pc === 16'd0 && iss_mask === 8'hFF && iss_slot === 3'd0,
        "R1 reset split", {4'd0, iss_valid, iss_slot, iss_mask, iss_pc}, {4'd0, 1'b1, 3'd0, 8'hFF, 16'd0});
    chk(err_overflow === 1'b0, "R1 err low", {31'd0, err_overflow}, 32'd0);

    ev(3'd0, 2'd0, 8'h00, 16'd0,  16'd1,  8'hFF, 3'd0, "R6 step keeps slot");
    ev(3'd1, 2'd0, 8'h00, 16'd0,  16'd2,  8'hFF, 3'd0, "R10 init b0");
    ev(3'd2, 2'd0, 8'h55, 16'd10, 16'd3,  8'hAA, 3'd0, "R2 divergent branch");
    ev(3'd4, 2'd0, 8'h00, 16'd0,  16'd10, 8'h55, 3'd1, "R6 yield moves on");
    ev(3'd3, 2'd0, 8'h00, 16'd0,  16'd4,  8'hAA, 3'd0, "R3 sync parks split");
    ev(3'd2, 2'd0, 8'hAA, 16'd10, 16'd10, 8'hAA, 3'd0, "R5 no merge into blocked");
    ev(3'd3, 2'd0, 8'h00, 16'd0,  16'd11, 8'hFF, 3'd0, "R4 barrier merge");
    ev(3'd2, 2'd0, 8'h0F, 16'd20, 16'd12, 8'hF0, 3'd0, "R2 split again");
    ev(3'd2, 2'd0, 8'h30, 16'd20, 16'd13, 8'hC0, 3'd0, "R5 taken lanes join");
    ev(3'd4, 2'd0, 8'h00, 16'd0,  16'd20, 8'h3F, 3'd1, "R5 joined mask");
    ev(3'd3, 2'd1, 8'h00, 16'd0,  16'd21, 8'h3F, 3'd1, "R7 empty barrier");
    ev(3'd2, 2'd0, 8'h3F, 16'd14, 16'd14, 8'hFF, 3'd0, "R8 emptied slot freed");
    ev(3'd2, 2'd0, 8'h03, 16'd40, 16'd15, 8'hFC, 3'd0, "R9 alloc branch 1");
    ev(3'd2, 2'd0, 8'h0C, 16'd50, 16'd16, 8'hF0, 3'd0, "R9 alloc branch 2");
    ev(3'd4, 2'd0, 8'h00, 16'd0,  16'd40, 8'h03, 3'd1, "R9 lowest free slot 1");
    ev(3'd4, 2'd0, 8'h00, 16'd0,  16'd50, 8'h0C, 3'd2, "R9 next free slot 2");
    ev(3'd4, 2'd0, 8'h00, 16'd0,  16'd17, 8'hF0, 3'd0, "R6 pointer wraps");
    ev(3'd1, 2'd2, 8'h00, 16'd0,  16'd18, 8'hF0, 3'd0, "R10 init b2");
    ev(3'd3, 2'd2, 8'h00, 16'd0,  16'd19, 8'hF0, 3'd0, "R4 lone sync completes");

    @(negedge clk);
    ev_valid = 1'b0;
    @(posedge clk);
    #5;
    while (q.size() > 0) @(posedge clk);
    #5;
    chk(err_overflow === 1'b0, "R9 err stays low", {31'd0, err_overflow}, 32'd0);
    finish_run();
  end

endmodule